// File: doc/BRIEF.md
# Biphase-Mark Audio Transmitter

This block takes stereo PCM audio from a three-wire serial link (bit clock, word select, data) and turns it into a biphase-mark coded line signal of the kind used by consumer digital audio links. A deserializer recovers each left and right sample and moves it into a 24-bit audio field. It handles left-justified, I2S-style and right-justified framing at 16, 18, 20 or 24 bits. An encoder wraps every sample in a 32-slot subframe and drives the coded line.

All sampling and coding run on one system clock. The incoming bit clock is sampled in that clock domain and edge-detected. A divider makes one half-cell tick every `HC_DIV` system clocks, so a 64-bit serial frame and a 128-half-cell coded frame cover the same time when the bit clock period is `2*HC_DIV` system clocks. Format and width are static inputs. Channel status comes from a constant parameter.

Top module: `bmc_audio_tx`

## Requirements
- R1: While `rst_n` is low, `bmc_o` is 0.
- R2: With `fmt_i` = 0 (left-justified), the sample MSB is the bit sampled on the first bit-clock rising edge after a word-select change.
- R3: With `fmt_i` = 1 (I2S-style), the sample MSB is the bit sampled on the second bit-clock rising edge after a word-select change.
- R4: With `fmt_i` = 2 (right-justified, 32 bit clocks per channel), the sample LSB is the last bit sampled before the next word-select change.
- R5: `wsel_i` picks the width: 0 = 16, 1 = 18, 2 = 20, 3 = 24 bits. The recovered sample is placed at the top of the 24-bit audio field, and the unused low bits are 0.
- R6: Serial bits outside the selected sample window do not change the transmitted audio.
- R7: `bmc_o` toggles at the start of every data cell, and toggles again mid-cell only when the bit is 1.
- R8: Each subframe opens with an 8-half-cell preamble that contains a 3-half-cell run. Preamble runs (relative to the previous level) are: 3,1,1,3 on the left subframe of block frame 0; 3,3,1,1 on the other left subframes; and 3,2,1,2 on right subframes. Left and right subframes alternate.
- R9: Slots 4 to 27 carry the audio with the LSB first. Slots 28 and 29 (validity, user) are 0. Slot 31 gives even parity over slots 4 to 31.
- R10: A block is `BLOCK_FRAMES` frames long. Slot 30 of both subframes of frame f carries bit f of `CS_WORD` for f < 32, and 0 otherwise.
- R11: `bmc_o` changes only on a half-cell tick, one tick every `HC_DIV` clocks, so every line run lasts a whole multiple of `HC_DIV` clocks.
- R12: Word select high marks the left channel and low marks the right. Each stereo pair is sent once, left subframe first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System (oversampling) clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk_i | input | 1 | Serial bit clock, sampled by `clk` |
| lrck_i | input | 1 | Word select: 1 = left, 0 = right |
| sdat_i | input | 1 | Serial audio data, MSB first |
| fmt_i | input | 2 | Framing: 0 left-justified, 1 I2S-style, 2 right-justified, 3 as 0 |
| wsel_i | input | 2 | Sample width: 16/18/20/24 bits for 0..3 |
| bmc_o | output | 1 | Biphase-mark coded line output |

## Verification
The bench builds the block with `HC_DIV` = 2, `BLOCK_FRAMES` = 8 and `CS_WORD` = 32'hA5. With these values a full block, with its B-preamble recurrence and the non-trivial channel-status pattern, fits into a few frames. This makes it affordable to sweep all three framings against all four widths. For each of the twelve combinations, the bench decodes the line from run lengths alone, fills the unused serial slots with ones, and compares the recovered pairs with samples it shifted arithmetically into place.

// File: rtl/bmc_pkg.sv
package bmc_pkg;

  localparam int AUD_W = 24;

  typedef enum logic [1:0] {
    FMT_LEFT  = 2'd0,
    FMT_DELAY = 2'd1,
    FMT_RIGHT = 2'd2,
    FMT_SPARE = 2'd3
  } fmt_e;

  // sample width selected by the two-bit code
  function automatic int unsigned width_of(logic [1:0] w);
    case (w)
      2'd0:    return 16;
      2'd1:    return 18;
      2'd2:    return 20;
      default: return 24;
    endcase
  endfunction

  // slot index within a channel where the sample MSB arrives
  function automatic int unsigned first_idx(logic [1:0] fmt, logic [1:0] w,
                                            int unsigned slots);
    case (fmt)
      FMT_DELAY: return 1;
      FMT_RIGHT: return slots - width_of(w);
      default:   return 0;
    endcase
  endfunction

  // low bits of the audio field that stay zero for a given width
  function automatic logic [AUD_W-1:0] low_mask(logic [1:0] w);
    return (AUD_W'(1) << (AUD_W - width_of(w))) - AUD_W'(1);
  endfunction

  function automatic logic [AUD_W-1:0] msb_align(logic [AUD_W-1:0] raw,
                                                 logic [1:0] w);
    return raw << (AUD_W - width_of(w));
  endfunction

  // slots 4..31 of a subframe, bit 0 = slot 4
  function automatic logic [27:0] pack_slots(logic [AUD_W-1:0] aud, logic c);
    logic [26:0] body;
    body = {c, 1'b0, 1'b0, aud};
    return {^body, body};
  endfunction

  // preamble half-cells, MSB first, relative to a previous level of 0
  function automatic logic [7:0] preamble(logic left, logic blk);
    if (!left)    return 8'b1110_0100;
    else if (blk) return 8'b1110_1000;
    else          return 8'b1110_0010;
  endfunction

endpackage

// File: rtl/pcm_deser.sv
module pcm_deser
  import bmc_pkg::*;
#(
  parameter int CH_SLOTS = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sclk_i,
  input  logic             lrck_i,
  input  logic             sdat_i,
  input  logic [1:0]       fmt_i,
  input  logic [1:0]       wsel_i,
  output logic [AUD_W-1:0] pair_l,
  output logic [AUD_W-1:0] pair_r,
  output logic             pair_stb
);
  localparam int IDX_W = $clog2(CH_SLOTS);
  localparam logic [IDX_W-1:0] IDX_MAX = IDX_W'(CH_SLOTS - 1);

  logic sclk_q, sclk_qq, lrck_q, sdat_q, lrck_last;
  logic [IDX_W-1:0] idx, idx_now;
  logic [AUD_W-1:0] shreg, left_hold;
  logic rise, bound, in_win;

  assign rise  = sclk_q & ~sclk_qq;
  assign bound = rise && (lrck_q != lrck_last);

  always_comb begin
    int unsigned st, wd, ix;
    st = first_idx(fmt_i, wsel_i, CH_SLOTS);
    wd = width_of(wsel_i);
    if (bound)               idx_now = '0;
    else if (idx == IDX_MAX) idx_now = idx;
    else                     idx_now = idx + IDX_W'(1);
    ix = 32'(idx_now);
    in_win = (ix >= st) && (ix < st + wd);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q    <= 1'b0;
      sclk_qq   <= 1'b0;
      lrck_q    <= 1'b0;
      sdat_q    <= 1'b0;
      lrck_last <= 1'b0;
      idx       <= IDX_MAX;
      shreg     <= '0;
      left_hold <= '0;
      pair_l    <= '0;
      pair_r    <= '0;
      pair_stb  <= 1'b0;
    end else begin
      sclk_q   <= sclk_i;
      sclk_qq  <= sclk_q;
      lrck_q   <= lrck_i;
      sdat_q   <= sdat_i;
      pair_stb <= 1'b0;
      if (rise) begin
        lrck_last <= lrck_q;
        idx       <= idx_now;
        if (bound) begin
          shreg <= in_win ? {{(AUD_W-1){1'b0}}, sdat_q} : '0;
          if (lrck_last) begin
            left_hold <= msb_align(shreg, wsel_i);
          end else begin
            pair_l   <= left_hold;
            pair_r   <= msb_align(shreg, wsel_i);
            pair_stb <= 1'b1;
          end
        end else if (in_win) begin
          shreg <= {shreg[AUD_W-2:0], sdat_q};
        end
      end
    end
  end
endmodule

// File: rtl/bmc_encoder.sv
module bmc_encoder
  import bmc_pkg::*;
#(
  parameter int          HC_DIV       = 4,
  parameter int          BLOCK_FRAMES = 192,
  parameter logic [31:0] CS_WORD      = 32'h0000_0004
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [AUD_W-1:0] pair_l,
  input  logic [AUD_W-1:0] pair_r,
  output logic             bmc_o,
  output logic             hc_tick,
  output logic             cell_start,
  output logic             frame_start
);
  localparam int DIV_W = (HC_DIV > 1) ? $clog2(HC_DIV) : 1;
  localparam int FR_W  = (BLOCK_FRAMES > 1) ? $clog2(BLOCK_FRAMES) : 1;

  logic [DIV_W-1:0] div;
  logic [6:0]       hc;
  logic [FR_W-1:0]  fcnt;
  logic [AUD_W-1:0] cur_l, cur_r;
  logic             out_q, pol_q, pol_now, nxt, c_bit, half, is_left;
  logic [4:0]       bslot;
  logic [27:0]      word;
  logic [7:0]       pat;
  logic [2:0]       pre_idx;

  assign hc_tick     = (div == DIV_W'(HC_DIV - 1));
  assign bslot       = hc[5:1];
  assign half        = hc[0];
  assign is_left     = ~hc[6];
  assign frame_start = hc_tick && (hc == 7'd0);
  assign cell_start  = hc_tick && !half && ((bslot == 5'd0) || (bslot >= 5'd4));
  assign bmc_o       = out_q;

  always_comb begin
    c_bit   = (32'(fcnt) < 32) ? CS_WORD[5'(fcnt)] : 1'b0;
    word    = pack_slots(is_left ? cur_l : cur_r, c_bit);
    pat     = preamble(is_left, fcnt == '0);
    pre_idx = 3'd7 - {bslot[1:0], half};
    pol_now = ((bslot == 5'd0) && !half) ? out_q : pol_q;
    if (bslot < 5'd4) nxt = pat[pre_idx] ^ pol_now;
    else if (!half)   nxt = ~out_q;
    else              nxt = out_q ^ word[bslot - 5'd4];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div   <= '0;
      hc    <= '0;
      fcnt  <= '0;
      cur_l <= '0;
      cur_r <= '0;
      out_q <= 1'b0;
      pol_q <= 1'b0;
    end else begin
      div <= hc_tick ? '0 : div + DIV_W'(1);
      if (hc_tick) begin
        hc    <= hc + 7'd1;
        out_q <= nxt;
        pol_q <= pol_now;
        if (hc == 7'd0) begin
          cur_l <= pair_l;
          cur_r <= pair_r;
        end
        if (hc == 7'd127)
          fcnt <= (fcnt == FR_W'(BLOCK_FRAMES - 1)) ? '0 : fcnt + FR_W'(1);
      end
    end
  end
endmodule

// File: rtl/bmc_audio_tx.sv
module bmc_audio_tx
  import bmc_pkg::*;
#(
  parameter int          HC_DIV       = 4,
  parameter int          BLOCK_FRAMES = 192,
  parameter int          CH_SLOTS     = 32,
  parameter logic [31:0] CS_WORD      = 32'h0000_0004
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sclk_i,
  input  logic       lrck_i,
  input  logic       sdat_i,
  input  logic [1:0] fmt_i,
  input  logic [1:0] wsel_i,
  output logic       bmc_o
);
  logic [AUD_W-1:0] pair_l, pair_r;
  logic pair_stb, hc_tick, cell_start, frame_start;

  pcm_deser #(.CH_SLOTS(CH_SLOTS)) u_deser (
    .clk(clk), .rst_n(rst_n), .sclk_i(sclk_i), .lrck_i(lrck_i),
    .sdat_i(sdat_i), .fmt_i(fmt_i), .wsel_i(wsel_i),
    .pair_l(pair_l), .pair_r(pair_r), .pair_stb(pair_stb)
  );

  bmc_encoder #(
    .HC_DIV(HC_DIV), .BLOCK_FRAMES(BLOCK_FRAMES), .CS_WORD(CS_WORD)
  ) u_enc (
    .clk(clk), .rst_n(rst_n), .pair_l(pair_l), .pair_r(pair_r),
    .bmc_o(bmc_o), .hc_tick(hc_tick), .cell_start(cell_start),
    .frame_start(frame_start)
  );
endmodule

// File: rtl/bmc_audio_tx_chk.sv
module bmc_audio_tx_chk
  import bmc_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             bmc_o,
  input logic [1:0]       wsel_i,
  input logic             hc_tick,
  input logic             cell_start,
  input logic             pair_stb,
  input logic [AUD_W-1:0] pair_l,
  input logic [AUD_W-1:0] pair_r
);
  // R11
  line_only_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !hc_tick |=> $stable(bmc_o));

  // R7
  cell_edge_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cell_start |=> (bmc_o != $past(bmc_o)));

  // R5
  low_bits_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pair_stb |-> (((pair_l | pair_r) & low_mask(wsel_i)) == '0));

  // R12
  pair_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pair_stb |=> !pair_stb);
endmodule

bind bmc_audio_tx bmc_audio_tx_chk u_chk (
  .clk(clk), .rst_n(rst_n), .bmc_o(bmc_o), .wsel_i(wsel_i),
  .hc_tick(hc_tick), .cell_start(cell_start), .pair_stb(pair_stb),
  .pair_l(pair_l), .pair_r(pair_r)
);

// File: tb/sim_bmc_audio_tx.sv
module sim_bmc_audio_tx;
  localparam int          HC  = 2;
  localparam int          BLK = 8;
  localparam logic [31:0] CS  = 32'h0000_00A5;
  localparam int          NP  = 5;

  logic clk = 1'b0, rst_n = 1'b0, sclk = 1'b0, lrck = 1'b0, sdat = 1'b0;
  logic [1:0] fmt = 2'd0, wsel = 2'd0;
  logic bmc;

  always #10 clk = ~clk;

  bmc_audio_tx #(.HC_DIV(HC), .BLOCK_FRAMES(BLK), .CS_WORD(CS)) u0 (
    .clk(clk), .rst_n(rst_n), .sclk_i(sclk), .lrck_i(lrck), .sdat_i(sdat),
    .fmt_i(fmt), .wsel_i(wsel), .bmc_o(bmc)
  );

  int checks = 0, fails = 0, dchecks = 0, dfails = 0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic int wd_of(int wi);
    return (wi == 3) ? 24 : 16 + 2 * wi;
  endfunction

  // bench view of the serial slot contents; unused slots carry 1
  function automatic logic ser_bit(int f, int w, logic [23:0] s, int i);
    case (f)
      1:       return (i >= 1 && i <= w) ? s[w - i] : 1'b1;
      2:       return (i >= 32 - w) ? s[31 - i] : 1'b1;
      default: return (i < w) ? s[w - 1 - i] : 1'b1;
    endcase
  endfunction

  task automatic send_bit(input logic fs, input logic b);
    @(negedge clk);
    sclk = 1'b0; lrck = fs; sdat = b;
    repeat (HC) @(negedge clk);
    sclk = 1'b1;
    repeat (HC - 1) @(negedge clk);
  endtask

  task automatic send_chan(input logic fs, input logic [23:0] s, input int f,
                           input int w);
    for (int i = 0; i < 32; i++) send_bit(fs, ser_bit(f, w, s, i));
  endtask

  // ---------------- line decoder (run-length based) ----------------
  int st, runlen, pre_hc, pre_n, ptype, nbits, fr_ctr, misalign, rec_n;
  logic lvl, pend, have_l, seen_b;
  logic [27:0] bits;
  logic [23:0] hold_l;
  logic [23:0] rec_l [64];
  logic [23:0] rec_r [64];

  task automatic dchk(input bit ok, input string req, input logic [31:0] act,
                      input logic [31:0] exp);
    dchecks++;
    if (!ok) begin
      dfails++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic finish_sub();
    logic is_left;
    logic expc;
    is_left = (ptype != 2);
    // R9 parity, validity, user
    dchk((^bits == 1'b0) && (bits[25:24] == 2'b00), "R9 parity/V/U",
         {4'h0, bits}, {4'h0, bits[27:26], 2'b00, bits[23:0]});
    // R8 alternation
    dchk(is_left == !have_l, "R8 subframe order", 32'(ptype), 32'(have_l));
    if (is_left) begin
      if (ptype == 1) begin
        // R10 block length
        if (seen_b) dchk(fr_ctr == BLK - 1, "R10 block length", 32'(fr_ctr + 1), 32'(BLK));
        fr_ctr = 0;
        seen_b = 1'b1;
      end else begin
        fr_ctr++;
      end
    end
    if (seen_b) begin
      expc = (fr_ctr < 32) ? CS[fr_ctr] : 1'b0;
      dchk(bits[26] == expc, "R10 channel status", 32'(bits[26]), 32'(expc));
    end
    if (is_left) begin
      hold_l = bits[23:0];
      have_l = 1'b1;
    end else begin
      if (rec_n < 64) begin
        rec_l[rec_n] = hold_l;
        rec_r[rec_n] = bits[23:0];
        rec_n++;
      end
      have_l = 1'b0;
    end
  endtask

  task automatic take_bit(input logic b);
    bits[nbits] = b;
    nbits++;
    if (nbits == 28) begin
      finish_sub();
      st = 3;
    end
  endtask

  task automatic handle_run(input int n);
    int h;
    if (n % HC != 0) begin
      if (st != 0) misalign++;
      st = 0;
      return;
    end
    h = n / HC;
    case (st)
      0: if (h == 3) begin st = 1; pre_hc = 3; pre_n = 1; end
      1: begin
        pre_n++;
        if (pre_n == 2) ptype = h;
        pre_hc += h;
        if (pre_hc == 8) begin
          st = 2; nbits = 0; pend = 1'b0;
        end else if (pre_hc > 8) begin
          dchk(1'b0, "R8 preamble length", 32'(pre_hc), 32'd8);
          st = 0;
        end
      end
      2: begin
        if (h == 2 && !pend) take_bit(1'b0);
        else if (h == 1 && pend) begin pend = 1'b0; take_bit(1'b1); end
        else if (h == 1) pend = 1'b1;
        else begin
          dchk(1'b0, "R7 data cell run", 32'(h), 32'd2);
          st = 0;
        end
      end
      default: begin
        if (h == 3) begin st = 1; pre_hc = 3; pre_n = 1; end
        else begin
          dchk(1'b0, "R8 preamble missing", 32'(h), 32'd3);
          st = 0;
        end
      end
    endcase
  endtask

  always @(negedge clk) begin
    if (!rst_n) begin
      st = 0; runlen = 0; lvl = 1'b0; rec_n = 0; have_l = 1'b0;
      seen_b = 1'b0; fr_ctr = 0; misalign = 0; pend = 1'b0; nbits = 0;
    end else if (bmc === lvl) begin
      runlen++;
    end else begin
      handle_run(runlen);
      runlen = 1;
      lvl = bmc;
    end
  end

  // ---------------- stimulus ----------------
  logic [23:0] exp_l [NP];
  logic [23:0] exp_r [NP];
  logic [23:0] src_l [NP];
  logic [23:0] src_r [NP];

  initial begin
    fmt = 2'd0; wsel = 2'd0;
    repeat (10) @(negedge clk);
    // R1
    chk(bmc == 1'b0, "R1 reset level", 32'(bmc), 32'd0);
    for (int f = 0; f < 3; f++) begin
      for (int wi = 0; wi < 4; wi++) begin
        int w, found, ix;
        string req;
        w = wd_of(wi);
        req = (f == 0) ? "R2 R5 R6 R12" : (f == 1) ? "R3 R5 R6 R12" : "R4 R5 R6 R12";
        rst_n = 1'b0; sclk = 1'b0; lrck = 1'b0; sdat = 1'b0;
        fmt = 2'(f); wsel = 2'(wi);
        repeat (10) @(negedge clk);
        chk(bmc == 1'b0, "R1 reset level", 32'(bmc), 32'd0);
        for (int k = 0; k < NP; k++) begin
          logic [31:0] hl, hr;
          hl = (32'(k + 1) * 32'h9E37_79B1 + 32'(f * 4 + wi) * 32'h7F4A_7C15) >> 5;
          hr = (32'(k + 7) * 32'h85EB_CA6B + 32'(f * 4 + wi) * 32'h27D4_EB2F) >> 3;
          src_l[k] = 24'(hl) & ((24'(1) << w) - 24'd1);
          src_r[k] = 24'(hr) & ((24'(1) << w) - 24'd1);
          if (src_l[k] == 0) src_l[k] = 24'd1;
          exp_l[k] = src_l[k] << (24 - w);
          exp_r[k] = src_r[k] << (24 - w);
        end
        @(negedge clk);
        rst_n = 1'b1;
        send_chan(1'b0, 24'd0, 0, 24);
        for (int k = 0; k < NP; k++) begin
          send_chan(1'b1, src_l[k], f, w);
          send_chan(1'b0, src_r[k], f, w);
        end
        for (int k = 0; k < 3; k++) begin
          send_chan(1'b1, 24'd0, f, w);
          send_chan(1'b0, 24'd0, f, w);
        end
        repeat (128 * HC * 3) @(negedge clk);
        found = -1;
        for (int j = 0; j < rec_n; j++)
          if (found < 0 && rec_l[j] == exp_l[0] && rec_r[j] == exp_r[0]) found = j;
        chk(found >= 0, {req, " first pair seen"}, 32'(found), 32'd0);
        if (found >= 0) begin
          for (int k = 1; k < NP; k++) begin
            ix = found + k;
            if (ix < rec_n) begin
              chk(rec_l[ix] == exp_l[k], {req, " left"}, 32'(rec_l[ix]), 32'(exp_l[k]));
              chk(rec_r[ix] == exp_r[k], {req, " right"}, 32'(rec_r[ix]), 32'(exp_r[k]));
            end else begin
              chk(1'b0, {req, " pair missing"}, 32'(ix), 32'(rec_n));
            end
          end
        end
        // R11
        chk(misalign == 0, "R11 run granularity", 32'(misalign), 32'd0);
      end
    end
    $display("[TB] %0d tests run, %0d failed", checks + dchecks, fails + dfails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    $display("FAIL watchdog expired act=%0d exp=%0d", checks + dchecks, 0);
    $display("[TB] %0d tests run, %0d failed", checks + dchecks + 1, fails + dfails + 1);
    $finish;
  end
endmodule